// File: doc/BRIEF.md
# Protection Fault Latch Unit

This block sits between the analog protection comparators of an inductive LED flash driver and its digital control. It takes the raw comparator outputs: output overvoltage, current-source headroom lost, LED node below the short threshold, junction over-temperature, a separate "die has cooled" comparator, and supply under-voltage lockout. It resynchronises them to the system clock and folds them into a fault status byte that the host reads over the serial interface.

Any latched fault raises a stop request to the mode controller. That controller then halts the boost converter and turns off the current sources. A host read of the status byte clears the overvoltage and LED-short flags. The over-temperature flag ignores reads and stays set, keeping the stop request up, until the cooling comparator reports that the die is back below the hysteresis point. While under-voltage lockout is present, the block issues a register-file reset and keeps the status byte at its default of zero. The LED-short check runs only after the converter has been enabled continuously for a configurable blanking period, so that start-up transients are not mistaken for a shorted LED.

Top module: `prot_fault_latch`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the status byte reads 00h, stop_req_o is low and reg_reset_o is low.
- R2: Status byte layout: bit 7 is the overvoltage flag, bit 6 the LED-short flag and bit 5 the over-temperature flag. Bits 4:0 always read 0.
- R3: The overvoltage flag is set only when the overvoltage comparator and the headroom-lost comparator are both high after synchronisation. Either one alone never sets it.
- R4: The LED-short flag is set only when the short comparator is high after synchronisation, conv_en_i is high, and conv_en_i has already been high for BLANK_CYCLES consecutive clock edges. A short indication that ends inside the blanking window leaves the flag at 0.
- R5: Every comparator input passes through two synchronising flops. A comparator that goes high before clock edge k changes the status byte at edge k+2, which is the third edge the input has seen. The status byte is unchanged after edges k and k+1.
- R6: stop_req_o is high exactly when at least one of status bits 7:5 is set.
- R7: A clock edge with rd_fault_i high clears the overvoltage and LED-short flags, unless the same edge sets them again.
- R8: The over-temperature flag is set by the synchronised over-temperature comparator. A read does not clear it. It clears only on an edge where the synchronised cooling comparator is high and the over-temperature comparator is low.
- R9: A fault condition present at the same edge as a clearing read leaves its flag set.
- R10: While the synchronised under-voltage input is high, reg_reset_o is high. From the following edge onwards the status byte is held at 00h, and no fault can set a flag until under-voltage ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_ovp_i | input | 1 | Asynchronous output-overvoltage comparator |
| cmp_hdrm_i | input | 1 | Asynchronous comparator: current source out of regulation |
| cmp_short_i | input | 1 | Asynchronous comparator: LED node below short threshold |
| cmp_hot_i | input | 1 | Asynchronous over-temperature comparator |
| cmp_cool_i | input | 1 | Asynchronous comparator: die below trip minus hysteresis |
| cmp_uvlo_i | input | 1 | Asynchronous supply under-voltage lockout |
| conv_en_i | input | 1 | Converter enabled (synchronous, from mode controller) |
| rd_fault_i | input | 1 | One-cycle strobe: host reads the status byte |
| fault_byte_o | output | 8 | Fault status byte |
| stop_req_o | output | 1 | Request to stop converter and current sources |
| reg_reset_o | output | 1 | Global register-file reset during under-voltage |

## Verification
Several properties are checked on every cycle: the reserved bits stay zero, a read clears the clear-on-read flags when no new event is present, the over-temperature flag holds while the cooling comparator is low, under-voltage empties the byte, blanking stops the short flag from rising, and a coincident event beats a read. Other behaviour needs whole input sequences and is shown only by the bench scenarios. This includes the exact three-edge latency through the synchronisers, the requirement that overvoltage and headroom loss coincide, a short pulse ending inside the blanking window, and the order of recovery after under-voltage. A long random run compares the outputs against a bench model on every cycle.

// File: rtl/pfl_pkg.sv
// Package: shared constants for the protection fault latch.
// Assumes: the comparator vector is ordered by the CMP_* indices below.
package pfl_pkg;
    localparam int NUM_CMP   = 6;
    localparam int CMP_OVP   = 0;
    localparam int CMP_HDRM  = 1;
    localparam int CMP_SHORT = 2;
    localparam int CMP_HOT   = 3;
    localparam int CMP_COOL  = 4;
    localparam int CMP_UVLO  = 5;

    // Status byte positions (decoded by the host software)
    localparam int BIT_OVP   = 7;
    localparam int BIT_SHORT = 6;
    localparam int BIT_HOT   = 5;
    localparam int NUM_FLT   = 3;

    // Index of each flag inside the internal flag vector
    localparam int FLT_HOT   = 0;
    localparam int FLT_SHORT = 1;
    localparam int FLT_OVP   = 2;
endpackage

// File: rtl/pfl_sync.sv
// Module: multi-bit, multi-stage synchroniser for asynchronous comparator levels.
// Assumes: each bit is an independent slow level; no bus coherency is needed.
module pfl_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage captures the raw asynchronous level
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // Later stages let metastability settle
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pfl_blank.sv
// Module: blanking counter arming the LED-short check after converter start.
// Assumes: enable is synchronous; arms after BLANK_CYCLES edges of continuous enable.
module pfl_blank #(
    parameter int BLANK_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    output logic armed_o
);
    localparam int CW = $clog2(BLANK_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(BLANK_CYCLES);

    logic [CW-1:0] cnt_q;

    // Count enabled edges, saturate at the limit, restart when disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign armed_o = (cnt_q == LIMIT);
endmodule

// File: rtl/pfl_status.sv
// Module: fault flag storage with clear-on-read and hysteresis-cleared flags.
// Assumes: events are already synchronised; set has priority over read-clear.
module pfl_status
    import pfl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wipe_i,
    input  logic               rd_i,
    input  logic               ovp_evt_i,
    input  logic               short_evt_i,
    input  logic               hot_i,
    input  logic               cool_i,
    output logic [NUM_FLT-1:0] flag_o
);
    logic [NUM_FLT-1:0] flag_q;
    logic [NUM_FLT-1:0] evt;

    assign evt[FLT_OVP]   = ovp_evt_i;
    assign evt[FLT_SHORT] = short_evt_i;
    assign evt[FLT_HOT]   = hot_i;

    genvar g;
    generate
        for (g = 0; g < NUM_FLT; g++) begin : g_flag
            if (g == FLT_HOT) begin : g_hyst
                // Thermal flag: set by trip, cleared only by the cooling comparator
                always_ff @(posedge clk) begin
                    if (!rst_n || wipe_i)   flag_q[g] <= 1'b0;
                    else if (evt[g])        flag_q[g] <= 1'b1;
                    else if (cool_i)        flag_q[g] <= 1'b0;
                end
            end else begin : g_cor
                // Clear-on-read flag; a coincident event keeps it set
                always_ff @(posedge clk) begin
                    if (!rst_n || wipe_i)   flag_q[g] <= 1'b0;
                    else if (evt[g])        flag_q[g] <= 1'b1;
                    else if (rd_i)          flag_q[g] <= 1'b0;
                end
            end
        end
    endgenerate

    assign flag_o = flag_q;
endmodule

// File: rtl/prot_fault_latch.sv
// Module: protection fault latch top. Synchronises comparators, qualifies
// events, latches the fault byte, raises stop and register-reset requests.
// Assumes: rd_fault_i and conv_en_i are synchronous to clk.
module prot_fault_latch
    import pfl_pkg::*;
#(
    parameter int BLANK_CYCLES = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmp_ovp_i,
    input  logic       cmp_hdrm_i,
    input  logic       cmp_short_i,
    input  logic       cmp_hot_i,
    input  logic       cmp_cool_i,
    input  logic       cmp_uvlo_i,
    input  logic       conv_en_i,
    input  logic       rd_fault_i,
    output logic [7:0] fault_byte_o,
    output logic       stop_req_o,
    output logic       reg_reset_o
);
    logic [NUM_CMP-1:0] raw_cmp;
    logic [NUM_CMP-1:0] sync_q;
    logic               cool_s;
    logic               hot_s;
    logic               uvlo_s;
    logic               short_armed;
    logic               ovp_evt;
    logic               short_evt;
    logic [NUM_FLT-1:0] flags;

    // Gather raw comparator levels into one vector
    always_comb begin
        raw_cmp            = '0;
        raw_cmp[CMP_OVP]   = cmp_ovp_i;
        raw_cmp[CMP_HDRM]  = cmp_hdrm_i;
        raw_cmp[CMP_SHORT] = cmp_short_i;
        raw_cmp[CMP_HOT]   = cmp_hot_i;
        raw_cmp[CMP_COOL]  = cmp_cool_i;
        raw_cmp[CMP_UVLO]  = cmp_uvlo_i;
    end

    pfl_sync #(.WIDTH(NUM_CMP), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_cmp),
        .sync_o  (sync_q)
    );

    pfl_blank #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (conv_en_i),
        .armed_o  (short_armed)
    );

    assign cool_s    = sync_q[CMP_COOL];
    assign hot_s     = sync_q[CMP_HOT];
    assign uvlo_s    = sync_q[CMP_UVLO];
    assign ovp_evt   = sync_q[CMP_OVP] & sync_q[CMP_HDRM];
    assign short_evt = sync_q[CMP_SHORT] & short_armed & conv_en_i;

    pfl_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .wipe_i      (uvlo_s),
        .rd_i        (rd_fault_i),
        .ovp_evt_i   (ovp_evt),
        .short_evt_i (short_evt),
        .hot_i       (hot_s),
        .cool_i      (cool_s),
        .flag_o      (flags)
    );

    // Assemble the host-visible byte; low bits are reserved zeros
    always_comb begin
        fault_byte_o            = 8'h00;
        fault_byte_o[BIT_OVP]   = flags[FLT_OVP];
        fault_byte_o[BIT_SHORT] = flags[FLT_SHORT];
        fault_byte_o[BIT_HOT]   = flags[FLT_HOT];
    end

    assign stop_req_o  = |flags;
    assign reg_reset_o = uvlo_s;
endmodule

// File: rtl/pfl_chk.sv
// Module: assertion checker for the protection fault latch, bound to the top.
// Assumes: the internal names cool_s, ovp_evt, short_evt, short_armed exist in the top.
module pfl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_fault_i,
    input logic [7:0] fault_byte_o,
    input logic       reg_reset_o,
    input logic       cool_s,
    input logic       ovp_evt,
    input logic       short_evt,
    input logic       short_armed
);
    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_byte_o[4:0] == 5'b0);

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fault_i && !ovp_evt && !short_evt |=> fault_byte_o[7:6] == 2'b00);

    // R8
    hot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_byte_o[5] && !cool_s && !reg_reset_o |=> fault_byte_o[5]);

    // R10
    uvlo_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_reset_o |=> fault_byte_o == 8'h00);

    // R4
    blank_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !short_armed |=> !$rose(fault_byte_o[6]));

    // R9
    evt_beats_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_evt && !reg_reset_o |=> fault_byte_o[7]);
endmodule

bind prot_fault_latch pfl_chk u_pfl_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_fault_i   (rd_fault_i),
    .fault_byte_o (fault_byte_o),
    .reg_reset_o  (reg_reset_o),
    .cool_s       (cool_s),
    .ovp_evt      (ovp_evt),
    .short_evt    (short_evt),
    .short_armed  (short_armed)
);

// File: tb/tb_prot_fault_latch.sv
`timescale 1ns/1ps
// Bench: directed corner cases followed by seeded random stimulus,
// compared every cycle against a model built from the requirements.
module tb_prot_fault_latch;
    localparam int BLANK = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ovp, hdrm, shrt, hot, cool, uvlo, cen, rd;
    logic [7:0] fbyte;
    logic       stop, rreset;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    prot_fault_latch #(.BLANK_CYCLES(BLANK)) dut (
        .clk(clk), .rst_n(rst_n),
        .cmp_ovp_i(ovp), .cmp_hdrm_i(hdrm), .cmp_short_i(shrt),
        .cmp_hot_i(hot), .cmp_cool_i(cool), .cmp_uvlo_i(uvlo),
        .conv_en_i(cen), .rd_fault_i(rd),
        .fault_byte_o(fbyte), .stop_req_o(stop), .reg_reset_o(rreset)
    );

    // ---------------- reference model ----------------
    // Comparator order in model vectors: {uvlo,cool,hot,short,hdrm,ovp}
    logic [5:0] m_s1, m_s2;
    int         m_cnt;
    logic [2:0] m_flags;   // {ovp, short, hot}

    function automatic logic [2:0] next_flags(input logic [2:0] cur, input logic [5:0] s,
                                              input logic armed, input logic en, input logic rdv);
        logic [2:0] n;
        if (s[5]) return 3'b000;                              // R10
        n[2] = (s[0] & s[1]) | (cur[2] & ~rdv);               // R3 R7 R9
        n[1] = (s[2] & armed & en) | (cur[1] & ~rdv);         // R4 R7 R9
        n[0] = s[3] ? 1'b1 : (s[4] ? 1'b0 : cur[0]);          // R8
        return n;
    endfunction

    function automatic logic [7:0] to_byte(input logic [2:0] f);
        return {f, 5'b00000};                                  // R2
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_cnt <= 0; m_flags <= '0;
        end else begin
            m_s1    <= {uvlo, cool, hot, shrt, hdrm, ovp};
            m_s2    <= m_s1;
            m_cnt   <= !cen ? 0 : (m_cnt == BLANK ? BLANK : m_cnt + 1);
            m_flags <= next_flags(m_flags, m_s2, m_cnt == BLANK, cen, rd);
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [7:0] exp_b, input logic exp_s, input logic exp_r);
        checks++;
        if (fbyte !== exp_b || stop !== exp_s || rreset !== exp_r) begin
            errors++;
            $display("FAIL %s: byte=%02h stop=%0b rreset=%0b expected byte=%02h stop=%0b rreset=%0b",
                     req, fbyte, stop, rreset, exp_b, exp_s, exp_r);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_pulse();
        rd = 1'b1; step(1); rd = 1'b0;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int unsigned seed_val;
        rst_n = 1'b0; ovp = 0; hdrm = 0; shrt = 0; hot = 0; cool = 0; uvlo = 0; cen = 0; rd = 0;
        seed_val = $urandom(32'h0000_5A17);
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 reset state", 8'h00, 1'b0, 1'b0);

        // R3: neither overvoltage nor headroom loss alone sets a flag
        ovp = 1; step(5); chk("R3 ovp alone", 8'h00, 0, 0);
        ovp = 0; hdrm = 1; step(5); chk("R3 headroom alone", 8'h00, 0, 0);
        hdrm = 0; step(3);

        // R5 latency, R2 bit position, R6 stop
        ovp = 1; hdrm = 1;
        step(1); chk("R5 after first edge", 8'h00, 0, 0);
        step(1); chk("R5 after second edge", 8'h00, 0, 0);
        step(1); chk("R5 R2 overvoltage at bit 7", 8'h80, 1, 0);
        ovp = 0; hdrm = 0; step(3);
        chk("R6 stop held by latched flag", 8'h80, 1, 0);

        // R7 read clears
        read_pulse();
        chk("R7 read clears overvoltage", 8'h00, 0, 0);

        // R9 event coincident with read
        ovp = 1; hdrm = 1; step(5);
        read_pulse();
        chk("R9 event beats read", 8'h80, 1, 0);
        ovp = 0; hdrm = 0; step(4);
        read_pulse();
        chk("R7 cleared once event gone", 8'h00, 0, 0);

        // R8 over-temperature hold and hysteresis clear
        hot = 1; step(2); hot = 0; step(4);
        chk("R8 R2 thermal at bit 5", 8'h20, 1, 0);
        read_pulse(); step(2);
        chk("R8 read leaves thermal set", 8'h20, 1, 0);
        cool = 1; step(4);
        chk("R8 cooling clears thermal", 8'h00, 0, 0);
        cool = 0; step(2);

        // R4 blanking window
        cen = 1; shrt = 1; step(10);
        shrt = 0; step(10);
        chk("R4 short inside blanking ignored", 8'h00, 0, 0);
        shrt = 1; step(5);
        chk("R4 R2 short after blanking at bit 6", 8'h40, 1, 0);
        shrt = 0; cen = 0; step(3);
        read_pulse();
        chk("R7 read clears short", 8'h00, 0, 0);

        // R10 under-voltage
        hot = 1; step(2); hot = 0; step(4);
        chk("R10 setup thermal", 8'h20, 1, 0);
        uvlo = 1;
        step(1); chk("R10 reset not yet synchronised", 8'h20, 1, 0);
        step(1); chk("R10 register reset asserted", 8'h20, 1, 1);
        step(1); chk("R10 byte wiped", 8'h00, 0, 1);
        ovp = 1; hdrm = 1; hot = 1; step(6);
        chk("R10 faults blocked during lockout", 8'h00, 0, 1);
        ovp = 0; hdrm = 0; hot = 0; uvlo = 0; step(4);
        chk("R10 recovery clean", 8'h00, 0, 0);

        // Random phase: R3 R4 R6 R7 R8 R9 R10 against the model
        for (int i = 0; i < 4000; i++) begin
            chk("R3 R4 R6 R7 R8 R9 R10 random", to_byte(m_flags), |m_flags, m_s2[5]);
            ovp  = ($urandom % 4) == 0;
            hdrm = ($urandom % 3) == 0;
            shrt = ($urandom % 5) == 0;
            hot  = ($urandom % 40) == 0;
            cool = ($urandom % 8) == 0;
            rd   = ($urandom % 6) == 0;
            if (($urandom % 30) == 0) cen = ~cen;
            if (uvlo) uvlo = ($urandom % 4) != 0;
            else      uvlo = ($urandom % 300) == 0;
            step(1);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule